// File: doc/BRIEF.md
# Bidirectional Latch/Register Bus Transceiver

This block passes words between two shared buses, A and B, whose width is a parameter (18 bits by default). Each direction owns one storage word. A latch-enable and a direction clock set how that word behaves. With the latch-enable high the word tracks the source bus. With the latch-enable low it keeps its value, except that it loads the source bus when the direction clock falls. A per-direction output-enable decides whether the stored word is driven onto the far bus through tri-state drivers. The A-to-B enable is active high and the B-to-A enable is active low.

Every control input is sampled on a fast system clock `clk`, so the storage word changes only at a rising edge of `clk`. Transparency has a latency of one system cycle, and a fall of a direction clock is recognised when one `clk` sample shows it high and the next shows it low. Two outputs tell the environment when the block is driving each bus, so that other drivers can keep off. An active-low asynchronous reset clears both words.

Top module: `bus_xcvr`

## Requirements
- R1: While `rst_n` is low, both storage words are cleared to zero. After reset, with both latch-enables low and both direction clocks steady, enabling the outputs shows zero on bus B and on bus A.
- R2: While `ab_le` is high, the A-to-B word takes the value of bus A at every rising edge of `clk`. A change on A therefore reaches a driven bus B one `clk` edge later and not before.
- R3: While `ab_le` is low and `ab_clk` stays at one level (high or low) between samples, the A-to-B word holds, whatever bus A does.
- R4: While `ab_le` is low, the A-to-B word loads bus A at the rising `clk` edge where `ab_clk` is sampled low after being sampled high at the previous edge. A rise of `ab_clk` loads nothing.
- R5: `ab_oe` is active high. When it is 1, bus B carries the A-to-B word and `b_drive` is 1. When it is 0, the block releases bus B, so another driver's value is read back intact, and `b_drive` is 0.
- R6: The B-to-A direction follows R2 to R4 with `ba_le`, `ba_clk`, bus B as source and bus A as destination.
- R7: `ba_oe_n` is active low. When it is 0, bus A carries the B-to-A word and `a_drive` is 1. When it is 1, the block releases bus A and `a_drive` is 0.
- R8: If a latch-enable is high at the same `clk` edge where a fall of its direction clock is seen, the word takes the source bus value. Follow mode takes precedence over capture.
- R9: The two directions are independent. Latch-enable, clock and bus activity on one direction leaves the other direction's stored word unchanged.
- R10: `b_drive` equals `ab_oe` and `a_drive` equals the inverse of `ba_oe_n`, and these flags change in the same cycle as the enables, with no register in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset of both storage words |
| a_bus | inout | W | Bus A: source for A-to-B, destination for B-to-A |
| b_bus | inout | W | Bus B: source for B-to-A, destination for A-to-B |
| ab_le | input | 1 | A-to-B latch-enable, high = follow bus A |
| ab_clk | input | 1 | A-to-B capture clock, falling transition loads |
| ab_oe | input | 1 | A-to-B output-enable, active high |
| ba_le | input | 1 | B-to-A latch-enable, high = follow bus B |
| ba_clk | input | 1 | B-to-A capture clock, falling transition loads |
| ba_oe_n | input | 1 | B-to-A output-enable, active low |
| a_drive | output | 1 | High while the block drives bus A |
| b_drive | output | 1 | High while the block drives bus B |

## Verification
If a storage word is corrupt, the wrong value shows on the destination bus as soon as that direction's output-enable is active. For a word that should follow, this happens one `clk` edge after the source changes. For a word that should hold, it shows at the next read of the bus. A fall of the direction clock that is missed, or a load on a rising transition, shows as a stale or early value on the first read after that edge. A fault in the enable polarity shows at once as a wrong drive flag, or as a bench value on a released bus that does not read back intact.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    // Per-cycle action chosen for one storage word.
    typedef enum logic [1:0] {
        MODE_HOLD    = 2'd0,
        MODE_FOLLOW  = 2'd1,
        MODE_CAPTURE = 2'd2
    } lane_mode_e;

    // Follow has priority over capture (R8); a fall is high-then-low.
    function automatic lane_mode_e decode_mode(input logic le,
                                               input logic clk_prev,
                                               input logic clk_now);
        if (le)
            return MODE_FOLLOW;
        else if (clk_prev && !clk_now)
            return MODE_CAPTURE;
        else
            return MODE_HOLD;
    endfunction

endpackage

// File: rtl/xcvr_lane.sv
module xcvr_lane #(
    parameter int W       = 18,
    parameter bit OE_HIGH = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] src,
    input  logic         le,
    input  logic         dir_clk,
    input  logic         oe,
    output logic [W-1:0] word,
    output logic         drive
);
    import xcvr_pkg::*;

    typedef struct packed {
        logic [W-1:0] word;
        logic         clk_prev;
    } lane_state_t;

    lane_state_t state_d, state_q;
    lane_mode_e  mode;

    always_comb begin
        state_d          = state_q;
        mode             = decode_mode(le, state_q.clk_prev, dir_clk);
        state_d.clk_prev = dir_clk;
        if (mode != MODE_HOLD)
            state_d.word = src;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= '0;
        else
            state_q <= state_d;
    end

    assign word = state_q.word;

    generate
        if (OE_HIGH) begin : g_oe_high
            assign drive = oe;
        end else begin : g_oe_low
            assign drive = ~oe;
        end
    endgenerate

endmodule

// File: rtl/xcvr_tsdrv.sv
module xcvr_tsdrv #(
    parameter int W = 18
) (
    input  logic         en,
    input  logic [W-1:0] val,
    inout  wire  [W-1:0] pad
);
    assign pad = en ? val : {W{1'bz}};
endmodule

// File: rtl/bus_xcvr.sv
module bus_xcvr #(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    inout  wire  [W-1:0] a_bus,
    inout  wire  [W-1:0] b_bus,
    input  logic         ab_le,
    input  logic         ab_clk,
    input  logic         ab_oe,
    input  logic         ba_le,
    input  logic         ba_clk,
    input  logic         ba_oe_n,
    output logic         a_drive,
    output logic         b_drive
);
    logic [W-1:0] ab_word;
    logic [W-1:0] ba_word;

    xcvr_lane #(.W(W), .OE_HIGH(1'b1)) u_lane_ab (
        .clk     (clk),
        .rst_n   (rst_n),
        .src     (a_bus),
        .le      (ab_le),
        .dir_clk (ab_clk),
        .oe      (ab_oe),
        .word    (ab_word),
        .drive   (b_drive)
    );

    xcvr_lane #(.W(W), .OE_HIGH(1'b0)) u_lane_ba (
        .clk     (clk),
        .rst_n   (rst_n),
        .src     (b_bus),
        .le      (ba_le),
        .dir_clk (ba_clk),
        .oe      (ba_oe_n),
        .word    (ba_word),
        .drive   (a_drive)
    );

    xcvr_tsdrv #(.W(W)) u_drv_b (
        .en  (b_drive),
        .val (ab_word),
        .pad (b_bus)
    );

    xcvr_tsdrv #(.W(W)) u_drv_a (
        .en  (a_drive),
        .val (ba_word),
        .pad (a_bus)
    );

endmodule

// File: rtl/xcvr_chk.sv
module xcvr_chk #(
    parameter int W = 18
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] a_bus,
    input logic [W-1:0] b_bus,
    input logic         ab_le,
    input logic         ab_clk,
    input logic         ab_oe,
    input logic         ba_le,
    input logic         ba_clk,
    input logic         ba_oe_n,
    input logic [W-1:0] ab_word,
    input logic [W-1:0] ba_word
);
    // High once a full out-of-reset cycle has passed, so $past is valid.
    logic armed;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            armed <= 1'b0;
        else
            armed <= 1'b1;
    end

    // R2
    ab_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ab_le |=> ab_word == $past(a_bus));

    // R3
    ab_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ab_le && !(armed && $past(ab_clk) && !ab_clk)) |=> $stable(ab_word));

    // R4
    ab_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ab_le && armed && $past(ab_clk) && !ab_clk) |=> ab_word == $past(a_bus));

    // R6
    ba_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ba_le |=> ba_word == $past(b_bus));

    // R6
    ba_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ba_le && !(armed && $past(ba_clk) && !ba_clk)) |=> $stable(ba_word));

    // R5
    b_drive_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ab_oe |-> b_bus == ab_word);

    // R7
    a_drive_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ba_oe_n |-> a_bus == ba_word);

endmodule

bind bus_xcvr xcvr_chk #(.W(W)) u_xcvr_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .a_bus   (a_bus),
    .b_bus   (b_bus),
    .ab_le   (ab_le),
    .ab_clk  (ab_clk),
    .ab_oe   (ab_oe),
    .ba_le   (ba_le),
    .ba_clk  (ba_clk),
    .ba_oe_n (ba_oe_n),
    .ab_word (ab_word),
    .ba_word (ba_word)
);

// File: tb/test_bus_xcvr.sv
`timescale 1ns/1ps
module test_bus_xcvr;
    localparam int W = 18;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ab_le = 1'b0, ab_clk = 1'b0, ab_oe = 1'b0;
    logic         ba_le = 1'b0, ba_clk = 1'b0, ba_oe_n = 1'b1;
    logic         a_drive, b_drive;
    logic [W-1:0] a_tv = '0, b_tv = '0;
    logic         a_te = 1'b0, b_te = 1'b0;
    wire  [W-1:0] a_bus, b_bus;
    int           checks = 0;
    int           fails = 0;
    bit           done = 1'b0;

    assign a_bus = a_te ? a_tv : {W{1'bz}};
    assign b_bus = b_te ? b_tv : {W{1'bz}};

    always #2.5 clk = ~clk;

    bus_xcvr #(.W(W)) i_bus_xcvr (
        .clk(clk), .rst_n(rst_n), .a_bus(a_bus), .b_bus(b_bus),
        .ab_le(ab_le), .ab_clk(ab_clk), .ab_oe(ab_oe),
        .ba_le(ba_le), .ba_clk(ba_clk), .ba_oe_n(ba_oe_n),
        .a_drive(a_drive), .b_drive(b_drive)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Bench must never drive a bus that the block is driving.
    always @(negedge clk) begin
        if (rst_n && ((a_te && a_drive) || (b_te && b_drive))) begin
            fails++;
            $display("FAIL R10: bus contention actual a=%b/%b b=%b/%b expected no overlap",
                     a_te, a_drive, b_te, b_drive);
        end
    end

    task automatic t_reset();
        step();
        rst_n = 1'b1;
        step();
        ab_oe = 1'b1; ba_oe_n = 1'b0;
        #1;
        chk("R1 b after reset", b_bus, '0);
        chk("R1 a after reset", a_bus, '0);
        ab_oe = 1'b0; ba_oe_n = 1'b1;
    endtask

    task automatic t_ab_transparent();
        a_te = 1'b1; a_tv = 18'h2A5C3; ab_le = 1'b1; ab_oe = 1'b1;
        step();
        chk("R2 follow first", b_bus, 18'h2A5C3);
        a_tv = 18'h15A3C;
        #1;
        chk("R2 one-cycle latency", b_bus, 18'h2A5C3);
        step();
        chk("R2 follow second", b_bus, 18'h15A3C);
        ab_le = 1'b0;
        step();
    endtask

    task automatic t_ab_hold();
        a_tv = 18'h3FFFF;
        step();
        chk("R3 hold clk low", b_bus, 18'h15A3C);
        ab_clk = 1'b1;
        step();
        a_tv = 18'h00001;
        step();
        step();
        chk("R3 hold clk high", b_bus, 18'h15A3C);
    endtask

    task automatic t_ab_capture();
        a_tv = 18'h0F0F0; ab_clk = 1'b0;
        step();
        chk("R4 capture on fall", b_bus, 18'h0F0F0);
        a_tv = 18'h30303; ab_clk = 1'b1;
        step();
        chk("R4 rise loads nothing", b_bus, 18'h0F0F0);
        ab_clk = 1'b0;
        step();
        chk("R4 second fall", b_bus, 18'h30303);
    endtask

    task automatic t_ab_oe();
        ab_oe = 1'b0;
        #1;
        chk("R5 b_drive low", {17'd0, b_drive}, '0);
        b_te = 1'b1; b_tv = 18'h1234A;
        #1;
        chk("R5 bus b released", b_bus, 18'h1234A);
        step();
        b_te = 1'b0; ab_oe = 1'b1;
        #1;
        chk("R5 b_drive high", {17'd0, b_drive}, 18'd1);
        chk("R5 b driven again", b_bus, 18'h30303);
    endtask

    task automatic t_ba_modes();
        ab_oe = 1'b0; a_te = 1'b0;
        b_te = 1'b1; b_tv = 18'h2BEEF; ba_le = 1'b1; ba_oe_n = 1'b0;
        step();
        chk("R6 ba follow", a_bus, 18'h2BEEF);
        ba_le = 1'b0; b_tv = 18'h11111;
        step();
        chk("R6 ba hold", a_bus, 18'h2BEEF);
        ba_clk = 1'b1;
        step();
        chk("R6 ba rise no load", a_bus, 18'h2BEEF);
        ba_clk = 1'b0;
        step();
        chk("R6 ba capture", a_bus, 18'h11111);
    endtask

    task automatic t_ba_oe();
        ba_oe_n = 1'b1;
        #1;
        chk("R7 a_drive low", {17'd0, a_drive}, '0);
        a_te = 1'b1; a_tv = 18'h0ABCD;
        #1;
        chk("R7 bus a released", a_bus, 18'h0ABCD);
        step();
        a_te = 1'b0; ba_oe_n = 1'b0;
        #1;
        chk("R7 a_drive high", {17'd0, a_drive}, 18'd1);
        chk("R7 a driven again", a_bus, 18'h11111);
    endtask

    task automatic t_priority();
        ba_oe_n = 1'b1; b_te = 1'b0; a_te = 1'b1; ab_oe = 1'b1;
        ab_clk = 1'b1; ab_le = 1'b0; a_tv = 18'h22222;
        step();
        a_tv = 18'h35555; ab_le = 1'b1; ab_clk = 1'b0;
        step();
        chk("R8 follow wins over fall", b_bus, 18'h35555);
        ab_le = 1'b0;
        step();
    endtask

    task automatic t_independence();
        // B-to-A activity must not disturb A-to-B word (35555).
        ab_oe = 1'b0; b_te = 1'b1;
        for (int i = 0; i < 4; i++) begin
            b_tv = 18'h01000 + 18'(i); ba_le = i[0]; ba_clk = i[1];
            a_tv = 18'h3C000 + 18'(i);
            step();
        end
        ba_le = 1'b0; ba_clk = 1'b0; b_tv = 18'h0C0DE;
        step();
        b_te = 1'b0; ab_oe = 1'b1;
        #1;
        chk("R9 ab word untouched", b_bus, 18'h35555);
        // A-to-B activity must not disturb B-to-A word (0C0DE captured above).
        ab_oe = 1'b0; b_te = 1'b1; b_tv = 18'h0C0DE;
        for (int i = 0; i < 4; i++) begin
            a_tv = 18'h2F000 + 18'(i); ab_le = i[0]; ab_clk = i[1];
            step();
        end
        ab_le = 1'b0; ab_clk = 1'b0;
        step();
        ba_le = 1'b0;
        b_te = 1'b0; a_te = 1'b0; ba_oe_n = 1'b0;
        #1;
        chk("R9 ba word untouched", a_bus, 18'h0C0DE);
        ba_oe_n = 1'b1;
    endtask

    task automatic t_drive_flags();
        a_te = 1'b0; b_te = 1'b0;
        for (int i = 0; i < 4; i++) begin
            ab_oe = i[0]; ba_oe_n = i[1];
            #1;
            chk("R10 b_drive", {17'd0, b_drive}, {17'd0, i[0]});
            chk("R10 a_drive", {17'd0, a_drive}, {17'd0, ~i[1]});
            step();
        end
        ab_oe = 1'b0; ba_oe_n = 1'b1;
    endtask

    initial begin
        t_reset();
        t_ab_transparent();
        t_ab_hold();
        t_ab_capture();
        t_ab_oe();
        t_ba_modes();
        t_ba_oe();
        t_priority();
        t_independence();
        t_drive_flags();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule